// File: doc/BRIEF.md
# Program Counter and Instruction Fetch Unit

This unit owns the program counter of a single-cycle processor and delivers the instruction word that the counter points at. A small on-block instruction store is filled through a write port, and that port works only while reset is held. Once reset is released, the store can only be read. Its read path is combinational, so the word for the current counter value is on the output in the same cycle.

On every rising clock edge the counter takes its next value. By default it advances to the following word, at counter plus four. When the decoder asks for a branch and the datapath reports equal operands, the counter instead moves to counter plus four plus the low 16 bits of the current instruction, sign-extended and multiplied by four. All address arithmetic wraps modulo 2^32. The store is indexed by counter bits [7:2], so a counter outside the first 256 bytes reads an aliased word.

Top module: `ifetch_unit`

## Requirements
- R1: While `rst_n` is low, `pc_o` is 0x00000000. This holds at once on assertion and for every cycle of reset.
- R2: `instr_o` equals the stored word at index `pc_o[7:2]` in the same cycle, with no clock edge in between.
- R3: At a clock edge where `br_sel` is 0, the next `pc_o` is the current `pc_o` + 4.
- R4: At a clock edge where `br_sel` and `zero_flag` are both 1, the next `pc_o` is `pc_o` + 4 + (sign-extended `instr_o[15:0]` × 4). Negative offsets move the counter backward.
- R5: The branch is taken only when both `br_sel` and `zero_flag` are 1. `br_sel`=1 with `zero_flag`=0 advances by 4, and so does `br_sel`=0 with `zero_flag`=1.
- R6: A write with `load_en`=1 stores `load_data` at word index `load_addr` only at a clock edge where `rst_n` is low. While `rst_n` is high the port has no effect on the stored words.
- R7: `pc_o[1:0]` is always 0.
- R8: Next-counter arithmetic wraps modulo 2^32. A branch below zero gives an address near 0xFFFFFFFC, and counter 0xFFFFFFFC + 4 gives 0.
- R9: A counter above 0xFF reads the word selected by bits [7:2] alone. For example, counter 0xFFFFFFFC reads word 63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low asynchronous reset; also enables the load port |
| load_en | input | 1 | Write strobe for the instruction store (reset only) |
| load_addr | input | 6 | Word index to write |
| load_data | input | 32 | Word to write |
| br_sel | input | 1 | Branch-type instruction indicator: 0 = advance by 4, 1 = branch if equal |
| zero_flag | input | 1 | Operands-equal condition from the datapath |
| pc_o | output | 32 | Current program counter |
| instr_o | output | 32 | Instruction word at the current counter |

## Verification
Two functions can fall on the same edge: the next-address choice and an attempted store write. The bench provokes this by asserting `load_en` with a fresh word aimed at an upcoming location while the counter is stepping or branching. It then judges that the counter followed its own rule and that, when the counter later reaches that location, the original word is returned. A second overlap is a branch whose target wraps past zero. This overlap is judged at the following edge: the counter must land at 0xFFFFFFFC, read word 63, and then roll over to zero.

// File: rtl/ifetch_pkg.sv
package ifetch_pkg;
    localparam int unsigned IFU_AW  = 32;
    localparam int unsigned IFU_DW  = 32;
    localparam int unsigned IFU_IMM = 16;

    typedef struct packed {
        logic [IFU_AW-1:0] pc;
    } ifu_state_t;
endpackage

// File: rtl/ifetch_imem.sv
module ifetch_imem #(
    parameter int unsigned DW    = 32,
    parameter int unsigned IDX_W = 6
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [DW-1:0]    wdata,
    input  logic [IDX_W-1:0] raddr,
    output logic [DW-1:0]    rdata
);
    localparam int unsigned DEPTH = 1 << IDX_W;

    logic [DW-1:0] word_q [DEPTH];

    for (genvar w = 0; w < DEPTH; w++) begin : g_word
        logic [DW-1:0] word_d;
        always_comb begin
            word_d = word_q[w];
            if (we && (waddr == IDX_W'(w))) begin
                word_d = wdata;
            end
        end
        always_ff @(posedge clk) begin
            word_q[w] <= word_d;
        end
    end

    assign rdata = word_q[raddr];
endmodule

// File: rtl/ifetch_offset.sv
module ifetch_offset #(
    parameter int unsigned AW    = 32,
    parameter int unsigned IMM_W = 16
) (
    input  logic [IMM_W-1:0] imm,
    output logic [AW-1:0]    byte_off
);
    localparam int unsigned EXT_W = AW - IMM_W - 2;

    assign byte_off = {{EXT_W{imm[IMM_W-1]}}, imm, 2'b00};
endmodule

// File: rtl/ifetch_next.sv
module ifetch_next #(
    parameter int unsigned AW = 32
) (
    input  logic [AW-1:0] pc,
    input  logic [AW-1:0] byte_off,
    input  logic          br_sel,
    input  logic          zero_flag,
    output logic [AW-1:0] pc_next
);
    localparam logic [AW-1:0] WORD_BYTES = AW'(4);

    logic [AW-1:0] seq_pc;
    logic [AW-1:0] tgt_pc;
    logic          take;

    always_comb begin
        seq_pc  = pc + WORD_BYTES;
        tgt_pc  = seq_pc + byte_off;
        take    = br_sel & zero_flag;
        pc_next = take ? tgt_pc : seq_pc;
    end
endmodule

// File: rtl/ifetch_unit.sv
module ifetch_unit
    import ifetch_pkg::*;
#(
    parameter int unsigned IDX_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [IDX_W-1:0]  load_addr,
    input  logic [IFU_DW-1:0] load_data,
    input  logic              br_sel,
    input  logic              zero_flag,
    output logic [IFU_AW-1:0] pc_o,
    output logic [IFU_DW-1:0] instr_o
);
    localparam int unsigned IDX_LO = 2;
    localparam int unsigned IDX_HI = IDX_W + IDX_LO - 1;

    ifu_state_t        st_d, st_q;
    logic [IFU_AW-1:0] byte_off;
    logic [IFU_AW-1:0] pc_next;
    logic              store_we;

    assign store_we = load_en & ~rst_n;

    ifetch_imem #(.DW(IFU_DW), .IDX_W(IDX_W)) i_imem (
        .clk   (clk),
        .we    (store_we),
        .waddr (load_addr),
        .wdata (load_data),
        .raddr (st_q.pc[IDX_HI:IDX_LO]),
        .rdata (instr_o)
    );

    ifetch_offset #(.AW(IFU_AW), .IMM_W(IFU_IMM)) i_offset (
        .imm      (instr_o[IFU_IMM-1:0]),
        .byte_off (byte_off)
    );

    ifetch_next #(.AW(IFU_AW)) i_next (
        .pc        (st_q.pc),
        .byte_off  (byte_off),
        .br_sel    (br_sel),
        .zero_flag (zero_flag),
        .pc_next   (pc_next)
    );

    always_comb begin
        st_d    = st_q;
        st_d.pc = pc_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pc_o = st_q.pc;
endmodule

// File: rtl/ifetch_unit_chk.sv
module ifetch_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        br_sel,
    input logic        zero_flag,
    input logic [31:0] pc_o,
    input logic [31:0] instr_o
);
    AST_RESET_PC: assert property (@(posedge clk) !rst_n |-> pc_o == 32'h0); // R1

    AST_PC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        pc_o[1:0] == 2'b00); // R7

    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !(br_sel && zero_flag) |=> pc_o == $past(pc_o) + 32'd4); // R3

    AST_BRANCH_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (br_sel && zero_flag) |=> pc_o == $past(pc_o) + 32'd4
            + {{14{$past(instr_o[15])}}, $past(instr_o[15:0]), 2'b00}); // R4
endmodule

bind ifetch_unit ifetch_unit_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .br_sel    (br_sel),
    .zero_flag (zero_flag),
    .pc_o      (pc_o),
    .instr_o   (instr_o)
);

// File: tb/test_ifetch_unit.sv
module test_ifetch_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_en = 1'b0;
    logic [5:0]  load_addr = '0;
    logic [31:0] load_data = '0;
    logic        br_sel = 1'b0;
    logic        zero_flag = 1'b0;
    logic [31:0] pc_o;
    logic [31:0] instr_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    typedef struct {
        logic [31:0] pc;
        logic [31:0] instr;
        string       tag;
    } exp_t;

    exp_t        sb_q[$];
    logic [31:0] model [64];
    logic [31:0] exp_pc;

    always #5 clk = ~clk;

    ifetch_unit i_ifetch_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (load_en),
        .load_addr (load_addr),
        .load_data (load_data),
        .br_sel    (br_sel),
        .zero_flag (zero_flag),
        .pc_o      (pc_o),
        .instr_o   (instr_o)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // Driver: applies inputs for the coming edge and queues the expected result.
    task automatic step(input bit b, input bit z, input string tag,
                        input bit wr = 1'b0, input logic [5:0] wa = '0,
                        input logic [31:0] wd = '0);
        exp_t        e;
        logic [31:0] imm_off;
        br_sel    = b;
        zero_flag = z;
        load_en   = wr;
        load_addr = wa;
        load_data = wd;
        imm_off = {{14{model[exp_pc[7:2]][15]}}, model[exp_pc[7:2]][15:0], 2'b00};
        if (b && z) exp_pc = exp_pc + 32'd4 + imm_off;
        else        exp_pc = exp_pc + 32'd4;
        e.pc    = exp_pc;
        e.instr = model[exp_pc[7:2]];
        e.tag   = tag;
        sb_q.push_back(e);
        @(negedge clk);
        load_en = 1'b0;
    endtask

    // Monitor: compares after each active edge.
    always @(posedge clk) begin
        #1;
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            chk(pc_o == e.pc, e.tag, pc_o, e.pc);
            chk(instr_o == e.instr, {e.tag, " R2 instr"}, instr_o, e.instr);
            chk(pc_o[1:0] == 2'b00, "R7 alignment", {30'd0, pc_o[1:0]}, 32'd0);
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%08h expected=%08h", 32'd0, 32'd1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] lfsr;
        for (int i = 0; i < 64; i++) begin
            model[i] = {8'hC3, 2'b00, 6'(i), 16'h0003};
        end
        model[7] = {8'hC3, 2'b00, 6'd7, 16'hFFF9};
        model[2] = {8'hC3, 2'b00, 6'd2, 16'hFFFC};

        // Fill the store while reset is held (R6).
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            load_en   = 1'b1;
            load_addr = 6'(i);
            load_data = model[i];
        end
        @(negedge clk);
        load_en = 1'b0;
        chk(pc_o == 32'h0, "R1 pc during reset", pc_o, 32'h0);

        rst_n  = 1'b1;
        exp_pc = 32'h0;
        #1;
        chk(pc_o == 32'h0, "R1 pc after release", pc_o, 32'h0);
        chk(instr_o == model[0], "R2 word 0", instr_o, model[0]);

        step(1'b0, 1'b0, "R3 sequential");            // -> 4
        step(1'b0, 1'b1, "R5 zero without br_sel");   // -> 8
        step(1'b1, 1'b0, "R5 br_sel without zero");   // -> 12
        step(1'b1, 1'b1, "R4 forward branch");        // -> 28
        step(1'b1, 1'b1, "R4 backward branch");       // -> 4
        // Write attempt to word 2 while running must be ignored (R6).
        step(1'b0, 1'b0, "R6 write ignored, pc", 1'b1, 6'd2, 32'hDEAD_BEEF); // -> 8
        chk(instr_o == model[2], "R6 word 2 unchanged", instr_o, model[2]);
        step(1'b1, 1'b1, "R8 branch below zero");     // -> FFFFFFFC
        chk(instr_o == model[63], "R9 alias word 63", instr_o, model[63]);
        step(1'b0, 1'b0, "R8 wrap to zero");          // -> 0

        lfsr = 32'hACE1_0001;
        for (int n = 0; n < 60; n++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            step(lfsr[3], lfsr[7], "R3/R4 mixed", lfsr[11], lfsr[17:12], lfsr);
        end

        // Mid-run reset (R1).
        rst_n = 1'b0;
        #1;
        chk(pc_o == 32'h0, "R1 async reset", pc_o, 32'h0);
        @(negedge clk);
        chk(pc_o == 32'h0, "R1 held in reset", pc_o, 32'h0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule